// File: doc/BRIEF.md
# Paged Nonvolatile Write Controller

This block is the write engine of a byte-wide nonvolatile memory that the host bus treats like an SRAM. The host issues a write by pulling the chip-select and write strobes low with the read strobe high. The block takes the address when the write becomes active and the data when it ends, and stores the byte in a page buffer. More bytes of the same page may follow. Once the bus has been quiet for a set number of clocks, the block commits the whole buffer to the storage array in one self-timed programming cycle. The storage array sits outside the block, behind a simple write port and an asynchronous read port.

While the programming cycle runs, reads do not reach the array. Bit 7 of a read returns the complement of bit 7 of the last byte loaded. Bit 6 changes on each new read. Once programming ends, reads return array data again. Write strobes that arrive while the block is busy have no effect.

The controller has four states. IDLE moves to LOAD when the first byte is stored. LOAD moves to COMMIT when the load window expires. COMMIT moves to WAIT after it has visited every buffer slot. WAIT moves to IDLE when the programming time has elapsed, and the buffer is cleared on that move.

Top module: `eeprom_pgwr`

## Requirements
- R1: After reset, busy, arr_we and dout_en are low and the block is in IDLE.
- R2: A single byte write is committed to the array at the address that was latched, and a later read of that address returns the byte.
- R3: A page write commits every loaded byte in one programming cycle. Array bytes of that page that were not loaded keep their previous contents.
- R4: Programming (busy high) starts on the LOAD_CYC-th clock edge after the edge that samples the end of the last write. Each new byte restarts this window.
- R5: During LOAD, a write whose address bits [12:6] differ from the page of the first byte is ignored. Address bits [5:0] select the slot, and a later write to a slot overwrites the earlier one.
- R6: busy stays high for exactly PROG_CYC clock cycles per programming cycle.
- R7: While busy, read bit 7 is the complement of bit 7 of the last byte loaded. After busy falls, reads return the true stored data.
- R8: While busy, read bit 6 alternates between successive reads. After busy falls it no longer alternates.
- R9: Write strobes while busy are ignored. They change no array byte and start no new page.
- R10: The address is captured when the later of write strobe or chip select falls (read strobe high), and the data is captured when the write ends. Later address changes have no effect.
- R11: dout_en is high only while chip select and read strobe are low and the write strobe is high.
- R12: arr_we pulses only while busy, once for each distinct loaded slot, and every pulse in one cycle targets the same page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Read strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data from bus |
| dout | output | 8 | Read data or polling status |
| dout_en | output | 1 | Output drive enable for the data bus |
| busy | output | 1 | Programming cycle in progress |
| arr_we | output | 1 | Array write enable |
| arr_addr | output | ADDR_W | Array address (commit slot while committing, else bus address) |
| arr_wdata | output | 8 | Array write data |
| arr_rdata | input | 8 | Array read data for arr_addr |

## Verification
The bench builds the block with LOAD_CYC = 20 and PROG_CYC = 100 instead of the real-time defaults of 15,000 and 200,000 cycles. With these values, the exact cycle on which programming starts, the exact length of busy, several full page cycles, and reads and writes attempted in the middle of a programming cycle all fit in a short run. PROG_CYC stays above the 64-slot commit walk, so the commit phase and the idle tail of WAIT both occur in each cycle.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOAD   = 2'd1,
        ST_COMMIT = 2'd2,
        ST_WAIT   = 2'd3
    } pgw_state_e;
endpackage

// File: rtl/pgw_strobe.sv
module pgw_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    output logic wr_start,
    output logic wr_end,
    output logic rd_start,
    output logic rd_act
);
    logic wr_act, wr_q, rd_q;

    assign wr_act = !ce_n && !we_n && oe_n;
    assign rd_act = !ce_n && !oe_n && we_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= 1'b0;
            rd_q <= 1'b0;
        end else begin
            wr_q <= wr_act;
            rd_q <= rd_act;
        end
    end

    assign wr_start = wr_act && !wr_q;
    assign wr_end   = !wr_act && wr_q;
    assign rd_start = rd_act && !rd_q;
endmodule

// File: rtl/pgw_pagebuf.sv
module pgw_pagebuf #(
    parameter int PAGE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [PAGE_W-1:0] wr_idx,
    input  logic [7:0]        wr_data,
    input  logic [PAGE_W-1:0] rd_idx,
    output logic              rd_valid,
    output logic [7:0]        rd_data
);
    localparam int SLOTS = 1 << PAGE_W;

    logic [SLOTS-1:0] valid;
    logic [7:0]       data [SLOTS];

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                valid[i] <= 1'b0;
            else if (clr)
                valid[i] <= 1'b0;
            else if (wr_en && (wr_idx == PAGE_W'(i)))
                valid[i] <= 1'b1;
        end

        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == PAGE_W'(i)))
                data[i] <= wr_data;
        end
    end

    assign rd_valid = valid[rd_idx];
    assign rd_data  = data[rd_idx];
endmodule

// File: rtl/pgw_status.sv
module pgw_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       busy,
    input  logic       rd_start,
    input  logic       byte_store,
    input  logic [7:0] byte_data,
    output logic [7:0] poll_byte
);
    logic [7:0] last_q;
    logic       tog_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= 8'h00;
            tog_q  <= 1'b0;
        end else begin
            if (byte_store)
                last_q <= byte_data;
            if (busy && rd_start)
                tog_q <= !tog_q;
        end
    end

    assign poll_byte = {!last_q[7], tog_q, last_q[5:0]};
endmodule

// File: rtl/eeprom_pgwr.sv
module eeprom_pgwr #(
    parameter int ADDR_W   = 13,
    parameter int PAGE_W   = 6,
    parameter int LOAD_CYC = 15000,
    parameter int PROG_CYC = 200000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              dout_en,
    output logic              busy,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [7:0]        arr_wdata,
    input  logic [7:0]        arr_rdata
);
    import pgw_pkg::*;

    localparam int SLOTS = 1 << PAGE_W;
    localparam int PG_W  = ADDR_W - PAGE_W;
    localparam int MAXC  = (LOAD_CYC > PROG_CYC) ? LOAD_CYC : PROG_CYC;
    localparam int CNT_W = $clog2(MAXC + 1);

    pgw_state_e        state, state_nx;
    logic [CNT_W-1:0]  cnt;
    logic [PG_W-1:0]   page_q;
    logic [PAGE_W-1:0] slot_q;
    logic              pend;

    logic wr_start, wr_end, rd_start, rd_act;
    logic acc_start, byte_store, buf_clr, in_commit;
    logic slot_valid;
    logic [7:0] slot_data, poll_byte;

    pgw_strobe u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .oe_n     (oe_n),
        .we_n     (we_n),
        .wr_start (wr_start),
        .wr_end   (wr_end),
        .rd_start (rd_start),
        .rd_act   (rd_act)
    );

    assign acc_start  = wr_start && ((state == ST_IDLE) ||
                        ((state == ST_LOAD) && (addr[ADDR_W-1:PAGE_W] == page_q)));
    assign byte_store = wr_end && pend;
    assign in_commit  = (state == ST_COMMIT);
    assign busy       = (state == ST_COMMIT) || (state == ST_WAIT);

    // next-state process
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (byte_store) state_nx = ST_LOAD;
            ST_LOAD:   if (!pend && !acc_start && !wr_end &&
                           (cnt == CNT_W'(LOAD_CYC - 1))) state_nx = ST_COMMIT;
            ST_COMMIT: if (cnt == CNT_W'(SLOTS - 1)) state_nx = ST_WAIT;
            ST_WAIT:   if (cnt == CNT_W'(PROG_CYC - 1)) state_nx = ST_IDLE;
        endcase
    end

    assign buf_clr = (state == ST_WAIT) && (state_nx == ST_IDLE);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // datapath registers: timer, page tag, slot latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            page_q <= '0;
            slot_q <= '0;
            pend   <= 1'b0;
        end else begin
            if (acc_start) begin
                slot_q <= addr[PAGE_W-1:0];
                if (state == ST_IDLE) page_q <= addr[ADDR_W-1:PAGE_W];
                pend <= 1'b1;
            end else if (wr_end) begin
                pend <= 1'b0;
            end

            unique case (state)
                ST_IDLE:   cnt <= '0;
                ST_LOAD:   if (pend || wr_end || state_nx == ST_COMMIT) cnt <= '0;
                           else cnt <= cnt + 1'b1;
                ST_COMMIT,
                ST_WAIT:   if (state_nx == ST_IDLE) cnt <= '0;
                           else cnt <= cnt + 1'b1;
            endcase
        end
    end

    pgw_pagebuf #(.PAGE_W(PAGE_W)) u_pagebuf (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (buf_clr),
        .wr_en    (byte_store),
        .wr_idx   (slot_q),
        .wr_data  (din),
        .rd_idx   (cnt[PAGE_W-1:0]),
        .rd_valid (slot_valid),
        .rd_data  (slot_data)
    );

    pgw_status u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy       (busy),
        .rd_start   (rd_start),
        .byte_store (byte_store),
        .byte_data  (din),
        .poll_byte  (poll_byte)
    );

    // output process
    always_comb begin
        arr_we    = in_commit && slot_valid;
        arr_wdata = slot_data;
        arr_addr  = in_commit ? {page_q, cnt[PAGE_W-1:0]} : addr;
        dout      = busy ? poll_byte : arr_rdata;
        dout_en   = rd_act;
    end
endmodule

// File: rtl/pgw_chk.sv
module pgw_chk #(
    parameter int PG_W     = 7,
    parameter int PROG_CYC = 200000
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ce_n,
    input logic            oe_n,
    input logic            busy,
    input logic            dout_en,
    input logic [7:0]      dout,
    input logic            arr_we,
    input logic [PG_W-1:0] arr_page
);
    int unsigned bcnt;

    always_ff @(posedge clk) begin
        if (!rst_n)    bcnt <= 0;
        else if (busy) bcnt <= bcnt + 1;
        else           bcnt <= 0;
    end

    p_arr_we_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy);

    p_one_page_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && $past(arr_we) && busy && $past(busy)) |-> (arr_page == $past(arr_page)));

    p_drive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> (!ce_n && !oe_n));

    p_busy_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (bcnt == PROG_CYC));

    p_poll_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && dout_en && $past(dout_en)) |-> $stable(dout[7]));
endmodule

bind eeprom_pgwr pgw_chk #(
    .PG_W     (ADDR_W - PAGE_W),
    .PROG_CYC (PROG_CYC)
) u_pgw_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .busy     (busy),
    .dout_en  (dout_en),
    .dout     (dout),
    .arr_we   (arr_we),
    .arr_page (arr_addr[ADDR_W-1:PAGE_W])
);

// File: tb/test_eeprom_pgwr.sv
module test_eeprom_pgwr;
    localparam int AW   = 13;
    localparam int LCYC = 20;
    localparam int PCYC = 100;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din = '0;
    logic [7:0]    dout, arr_wdata;
    logic          dout_en, busy, arr_we;
    logic [AW-1:0] arr_addr;
    logic [7:0]    arr_rdata;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    int we_pulses = 0;
    int busy_run = 0, busy_len = 0;
    logic [7:0] mem [logic [AW-1:0]];

    always #5 clk = !clk;

    eeprom_pgwr #(.ADDR_W(AW), .PAGE_W(6), .LOAD_CYC(LCYC), .PROG_CYC(PCYC)) i_eeprom_pgwr (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .busy(busy),
        .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata), .arr_rdata(arr_rdata)
    );

    // storage array model, erased value 0xFF
    always @(posedge clk) if (arr_we) begin
        mem[arr_addr] = arr_wdata;
        we_pulses++;
    end
    always @* arr_rdata = mem.exists(arr_addr) ? mem[arr_addr] : 8'hFF;

    always @(negedge clk) begin
        if (busy) busy_run++;
        else if (busy_run != 0) begin busy_len = busy_run; busy_run = 0; end
    end

    task automatic chk(input string req, input int got, input int exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; din = d; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] d, output logic en);
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk);
        d = dout; en = dout_en;
        ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 1000 && busy !== 1'b0; i++) @(negedge clk);
        repeat (LCYC + 2) @(negedge clk);
        for (int i = 0; i < 1000 && busy !== 1'b0; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d; logic en;
        chk("R1 busy", busy, 0);
        chk("R1 arr_we", arr_we, 0);
        chk("R1 dout_en", dout_en, 0);
        rd(13'h0010, d, en);
        chk("R11 dout_en on read", en, 1);
        chk("R11 erased read", d, 8'hFF);
        @(negedge clk);
        chk("R11 dout_en idle", dout_en, 0);
    endtask

    task automatic t_single();
        logic [7:0] d; logic en;
        we_pulses = 0;
        wr(13'h0123, 8'hA5);
        repeat (LCYC) @(posedge clk);
        @(negedge clk);
        chk("R4 not yet busy", busy, 0);
        @(negedge clk);
        chk("R4 busy starts", busy, 1);
        wait_idle();
        chk("R6 busy length", busy_len, PCYC);
        chk("R12 one pulse", we_pulses, 1);
        rd(13'h0123, d, en);
        chk("R2 byte stored", d, 8'hA5);
        rd(13'h0124, d, en);
        chk("R3 neighbour untouched", d, 8'hFF);
    endtask

    task automatic t_page();
        logic [7:0] d; logic en;
        we_pulses = 0;
        wr(13'h0205, 8'h11);
        repeat (LCYC - 5) @(negedge clk);
        wr(13'h0207, 8'h22);       // R4 window restarted
        wr(13'h023F, 8'h33);
        wr(13'h0240, 8'h44);       // R5 other page
        wr(13'h0205, 8'h55);       // R5 overwrite slot
        wait_idle();
        chk("R12 three pulses", we_pulses, 3);
        rd(13'h0205, d, en); chk("R5 overwrite", d, 8'h55);
        rd(13'h0207, d, en); chk("R3 page byte", d, 8'h22);
        rd(13'h023F, d, en); chk("R3 last slot", d, 8'h33);
        rd(13'h0240, d, en); chk("R5 other page ignored", d, 8'hFF);
        rd(13'h0206, d, en); chk("R3 unloaded slot", d, 8'hFF);
        wr(13'h0110, 8'h77);
        wait_idle();
        rd(13'h0110, d, en); chk("R3 new byte", d, 8'h77);
        rd(13'h0123, d, en); chk("R3 old byte kept", d, 8'hA5);
    endtask

    task automatic t_poll();
        logic [7:0] d1, d2; logic en;
        wr(13'h0300, 8'h9C);
        repeat (LCYC + 1) @(negedge clk);
        chk("R4 busy for poll", busy, 1);
        rd(13'h0555, d1, en);
        chk("R7 bit7 complement", d1[7], 0);
        rd(13'h0555, d2, en);
        chk("R8 bit6 toggles", d2[6], !d1[6]);
        wr(13'h0300, 8'h00);       // R9 ignored
        wr(13'h0400, 8'h12);       // R9 ignored
        rd(13'h0555, d1, en);
        chk("R8 bit6 toggles again", d1[6], !d2[6]);
        chk("R9 poll bit7 unchanged", d1[7], 0);
        wait_idle();
        chk("R9 busy not extended", busy_len, PCYC);
        rd(13'h0300, d1, en); chk("R7 true data", d1, 8'h9C);
        rd(13'h0300, d2, en); chk("R8 no toggle idle", d2, d1);
        rd(13'h0400, d1, en); chk("R9 no write while busy", d1, 8'hFF);
        wr(13'h0600, 8'h1C);
        repeat (LCYC + 1) @(negedge clk);
        rd(13'h0000, d1, en);
        chk("R7 bit7 complement of zero", d1[7], 1);
        wait_idle();
    endtask

    task automatic t_latch();
        logic [7:0] d; logic en;
        @(negedge clk);
        addr = 13'h0500; din = 8'h00; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        addr = 13'h0777; din = 8'h3C;
        @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1;
        @(negedge clk);
        we_n = 1'b0; addr = 13'h0501; din = 8'h00;
        @(negedge clk);
        ce_n = 1'b0;
        @(negedge clk);
        addr = 13'h0778; din = 8'hC3;
        @(negedge clk);
        ce_n = 1'b1;
        @(negedge clk);
        we_n = 1'b1;
        wait_idle();
        rd(13'h0500, d, en); chk("R10 addr at strobe fall", d, 8'h3C);
        rd(13'h0501, d, en); chk("R10 chip-select controlled", d, 8'hC3);
        rd(13'h0777, d, en); chk("R10 late addr ignored", d, 8'hFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_page();
        t_poll();
        t_latch();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule